// File: doc/BRIEF.md
# Slot-Based Power Sequencer

This block steps twelve supply-enable outputs through a timed power-up and power-down order. Time is divided into fifteen consecutive slots; every output carries one slot number for the rising order and another for the falling order, so a single configuration describes both directions. Slot length is derived from a one-byte time value and a selectable step size. All time is measured in ticks of a 1 µs strobe, `tick_us`.

A high level on `act_req` starts power-up. The enables switch on at the ends of their slots. After slot 15 a programmable delay runs, and then the system reset output is released. A low level on `act_req` asserts the reset at once and runs the falling order. Reversing the request in the middle of a sequence abandons it and starts the opposite sequence from the first slot. Two emergency inputs, `backup` and `failsafe`, drop every enable and hold the sequencer in shutdown for as long as either one is high.

Top module: `pwr_slot_seq`

## Requirements
- R1: While reset is asserted, and after its release with `act_req` low, every enable is 0, `sys_rst_n` is 0 and `seq_state` is 00.
- R2: The step is 250 ticks when `step_sel` is 0 and 1000 ticks when it is 1. An up slot lasts `up_time`×step + step/2 ticks. A down slot lasts `dn_time`×step + step/2 ticks.
- R3: Power-up starts at the clock edge where `act_req` is first seen high in shutdown. The up slot of output i is bits [4i+3:4i] of `up_slot_map`. An output with up slot s (1 to 15) goes high on the edge that carries the (s×L)-th tick after the start edge, where L is the up slot length.
- R4: An output whose slot number is 0 for the running direction keeps its present level through that whole sequence.
- R5: All fifteen up slots run, even empty ones. The reset delay D starts when slot 15 ends. D is 100×2^c ticks for a `rst_dly_code` c of 0 to 7, and 1000×2^(c−8) ticks for c of 8 to 15. `sys_rst_n` rises and `seq_state` becomes 11 on the (15L+D)-th tick. `seq_state` is 00 in every other condition.
- R6: Power-down starts at the edge where `act_req` is seen low after power-up began. `sys_rst_n` is 0 from that edge on. The down slot of output i is bits [4i+3:4i] of `dn_slot_map`. An output with down slot s goes low on the (s×Ld)-th tick, where Ld is the down slot length. After slot 15 the block is back in shutdown.
- R7: If `act_req` reverses during a sequence, the running sequence is abandoned at the edge that sees the change. A slot that ends on that same edge is not applied. The opposite sequence then starts from slot 1, counted from that edge.
- R8: A high `backup` or `failsafe` drives all enables to 0, `sys_rst_n` to 0 and `seq_state` to 00 at the next edge. This takes precedence over a slot ending on the same edge. The block stays in shutdown while either input is high. Once both are low with `act_req` high, power-up restarts from slot 1.
- R9: Slot and delay time advance only on edges where `tick_us` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| act_req | input | 1 | 1 = run up / stay active, 0 = shut down |
| backup | input | 1 | Emergency state, forces shutdown |
| failsafe | input | 1 | Emergency state, forces shutdown |
| step_sel | input | 1 | Slot step select: 0 = 250 µs, 1 = 1000 µs |
| up_time | input | 8 | Up slot time multiplier |
| dn_time | input | 8 | Down slot time multiplier |
| up_slot_map | input | 48 | Twelve 4-bit up slot numbers, output i at [4i+3:4i] |
| dn_slot_map | input | 48 | Twelve 4-bit down slot numbers, output i at [4i+3:4i] |
| rst_dly_code | input | 4 | Reset release delay code |
| en_out | output | 12 | Supply enable outputs |
| sys_rst_n | output | 1 | Active-low system reset |
| seq_state | output | 2 | 11 = active, 00 = shutdown or sequencing |

## Verification
A slot ending can land on the same clock edge as a request reversal or an emergency input. The bench provokes both cases. It computes the edge that carries the final tick of a chosen slot and changes `act_req` or `backup` on the preceding half cycle. In the reversal case it judges that the enable mapped to that slot never rises and that the falling order starts counting from that edge. In the emergency case it judges that every enable reads 0 on that edge. Every other expected change is placed by the bench on an exact edge, and the value one cycle earlier is also checked, so a slot length off by one tick is caught.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP,
    ST_DLY,
    ST_ON,
    ST_DN
  } seq_state_t;

  localparam logic [1:0] CODE_ON   = 2'b11;
  localparam logic [1:0] CODE_IDLE = 2'b00;
endpackage

// File: rtl/pss_rst_sync.sv
module pss_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/pss_len_calc.sv
module pss_len_calc #(
  parameter int TIME_W      = 8,
  parameter int DLY_W       = 4,
  parameter int CNT_W       = 18,
  parameter int STEP_SMALL  = 250,
  parameter int STEP_LARGE  = 1000,
  parameter int DLY_SHORT   = 100,
  parameter int DLY_LONG    = 1000
) (
  input  logic              step_sel,
  input  logic [TIME_W-1:0] up_time,
  input  logic [TIME_W-1:0] dn_time,
  input  logic [DLY_W-1:0]  dly_code,
  output logic [CNT_W-1:0]  up_len,
  output logic [CNT_W-1:0]  dn_len,
  output logic [CNT_W-1:0]  dly_len
);
  logic [CNT_W-1:0] step_w;
  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] dly_base;

  // Slot length: multiplier times step plus half a step
  assign step_w = step_sel ? CNT_W'(STEP_LARGE) : CNT_W'(STEP_SMALL);
  assign half_w = step_w >> 1;
  assign up_len = (CNT_W'(up_time) * step_w) + half_w;
  assign dn_len = (CNT_W'(dn_time) * step_w) + half_w;

  // Delay code: top bit picks the range, low bits are a power of two
  assign dly_base = dly_code[DLY_W-1] ? CNT_W'(DLY_LONG) : CNT_W'(DLY_SHORT);
  assign dly_len  = dly_base << dly_code[DLY_W-2:0];
endmodule

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign expire   = run && tick && cnt_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (len == '0) ? '0 : (len - CNT_W'(1));
    end else if (run && tick && !cnt_zero) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R9: without a tick or a reload the count must not move
  p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int CNT_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic              force_off,
  input  logic              expire,
  input  logic [CNT_W-1:0]  up_len,
  input  logic [CNT_W-1:0]  dn_len,
  input  logic [CNT_W-1:0]  dly_len,
  output logic              run,
  output logic              load,
  output logic [CNT_W-1:0]  load_len,
  output logic [SLOT_W-1:0] slot,
  output logic              evt_up,
  output logic              evt_dn,
  output logic              sys_rst_n,
  output logic [1:0]        state_code
);
  localparam logic [SLOT_W-1:0] SLOT_FIRST = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_LAST  = '1;

  seq_state_t        st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              rst_d;
  logic [1:0]        code_d;

  assign run  = (st_q == ST_UP) || (st_q == ST_DLY) || (st_q == ST_DN);
  assign slot = slot_q;

  always_comb begin
    st_d     = st_q;
    slot_d   = slot_q;
    load     = 1'b0;
    load_len = up_len;
    evt_up   = 1'b0;
    evt_dn   = 1'b0;
    if (force_off) begin
      st_d   = ST_OFF;
      slot_d = '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          if (act_req) begin
            st_d     = ST_UP;
            slot_d   = SLOT_FIRST;
            load     = 1'b1;
            load_len = up_len;
          end
        end
        ST_UP: begin
          if (!act_req) begin
            st_d     = ST_DN;
            slot_d   = SLOT_FIRST;
            load     = 1'b1;
            load_len = dn_len;
          end else if (expire) begin
            evt_up = 1'b1;
            load   = 1'b1;
            if (slot_q == SLOT_LAST) begin
              st_d     = ST_DLY;
              slot_d   = '0;
              load_len = dly_len;
            end else begin
              slot_d   = slot_q + 1'b1;
              load_len = up_len;
            end
          end
        end
        ST_DLY: begin
          if (!act_req) begin
            st_d     = ST_DN;
            slot_d   = SLOT_FIRST;
            load     = 1'b1;
            load_len = dn_len;
          end else if (expire) begin
            st_d = ST_ON;
          end
        end
        ST_ON: begin
          if (!act_req) begin
            st_d     = ST_DN;
            slot_d   = SLOT_FIRST;
            load     = 1'b1;
            load_len = dn_len;
          end
        end
        ST_DN: begin
          if (act_req) begin
            st_d     = ST_UP;
            slot_d   = SLOT_FIRST;
            load     = 1'b1;
            load_len = up_len;
          end else if (expire) begin
            evt_dn = 1'b1;
            if (slot_q == SLOT_LAST) begin
              st_d   = ST_OFF;
              slot_d = '0;
            end else begin
              slot_d   = slot_q + 1'b1;
              load     = 1'b1;
              load_len = dn_len;
            end
          end
        end
        default: begin
          st_d   = ST_OFF;
          slot_d = '0;
        end
      endcase
    end
    rst_d  = (st_d == ST_ON);
    code_d = rst_d ? CODE_ON : CODE_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OFF;
      slot_q     <= '0;
      sys_rst_n  <= 1'b0;
      state_code <= CODE_IDLE;
    end else begin
      st_q       <= st_d;
      slot_q     <= slot_d;
      sys_rst_n  <= rst_d;
      state_code <= code_d;
    end
  end

  // R5: reset is released only out of the delay phase
  p_rst_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> ($past(st_q) == ST_DLY));

  // R6: losing the request while active asserts reset on the next edge
  p_rst_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ON && !act_req) |=> !sys_rst_n);

  // R3: a running sequence always points at a real slot
  p_slot_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UP || st_q == ST_DN) |-> (slot_q != '0));

  // R8: emergency input lands in shutdown with reset asserted
  p_force_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (st_q == ST_OFF && !sys_rst_n && state_code == CODE_IDLE));
endmodule

// File: rtl/pss_en_bank.sv
module pss_en_bank #(
  parameter int N_EN   = 12,
  parameter int SLOT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     force_off,
  input  logic                     evt_up,
  input  logic                     evt_dn,
  input  logic [SLOT_W-1:0]        slot,
  input  logic [N_EN*SLOT_W-1:0]   up_map,
  input  logic [N_EN*SLOT_W-1:0]   dn_map,
  output logic [N_EN-1:0]          en_q
);
  logic [N_EN-1:0] en_d;

  for (genvar i = 0; i < N_EN; i++) begin : g_lane
    logic hit_up;
    logic hit_dn;
    // slot is never 0 while an event fires, so a 0 mapping never matches
    assign hit_up = (up_map[i*SLOT_W +: SLOT_W] == slot);
    assign hit_dn = (dn_map[i*SLOT_W +: SLOT_W] == slot);

    always_comb begin
      en_d[i] = en_q[i];
      if (force_off) begin
        en_d[i] = 1'b0;
      end else if (evt_up && hit_up) begin
        en_d[i] = 1'b1;
      end else if (evt_dn && hit_dn) begin
        en_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  // R3: an enable only rises on an up-slot event
  p_rise_on_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_up |=> ((en_q & ~$past(en_q)) == '0));

  // R6: an enable only falls on a down-slot event or an emergency
  p_fall_on_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_dn && !force_off) |=> ((~en_q & $past(en_q)) == '0));

  // R8: emergency clears every lane
  p_force_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (en_q == '0));
endmodule

// File: rtl/pwr_slot_seq.sv
module pwr_slot_seq #(
  parameter int N_EN          = 12,
  parameter int SLOT_W        = 4,
  parameter int TIME_W        = 8,
  parameter int DLY_W         = 4,
  parameter int STEP_SMALL_US = 250,
  parameter int STEP_LARGE_US = 1000,
  parameter int DLY_SHORT_US  = 100,
  parameter int DLY_LONG_US   = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_us,
  input  logic                   act_req,
  input  logic                   backup,
  input  logic                   failsafe,
  input  logic                   step_sel,
  input  logic [TIME_W-1:0]      up_time,
  input  logic [TIME_W-1:0]      dn_time,
  input  logic [N_EN*SLOT_W-1:0] up_slot_map,
  input  logic [N_EN*SLOT_W-1:0] dn_slot_map,
  input  logic [DLY_W-1:0]       rst_dly_code,
  output logic [N_EN-1:0]        en_out,
  output logic                   sys_rst_n,
  output logic [1:0]             seq_state
);
  localparam int STEP_MAX  = (STEP_LARGE_US > STEP_SMALL_US) ? STEP_LARGE_US : STEP_SMALL_US;
  localparam int SLOT_MAX  = ((2**TIME_W) - 1) * STEP_MAX + STEP_MAX / 2;
  localparam int DLY_UNIT  = (DLY_LONG_US > DLY_SHORT_US) ? DLY_LONG_US : DLY_SHORT_US;
  localparam int DLY_MAX   = DLY_UNIT * (2**((2**(DLY_W-1)) - 1));
  localparam int LEN_MAX   = (SLOT_MAX > DLY_MAX) ? SLOT_MAX : DLY_MAX;
  localparam int CNT_W     = $clog2(LEN_MAX + 1);

  logic              rst_i;
  logic              force_off;
  logic [CNT_W-1:0]  up_len, dn_len, dly_len, load_len;
  logic              run, load, expire, evt_up, evt_dn;
  logic [SLOT_W-1:0] slot;

  assign force_off = backup || failsafe;

  pss_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_i)
  );

  pss_len_calc #(
    .TIME_W     (TIME_W),
    .DLY_W      (DLY_W),
    .CNT_W      (CNT_W),
    .STEP_SMALL (STEP_SMALL_US),
    .STEP_LARGE (STEP_LARGE_US),
    .DLY_SHORT  (DLY_SHORT_US),
    .DLY_LONG   (DLY_LONG_US)
  ) u_len (
    .step_sel (step_sel),
    .up_time  (up_time),
    .dn_time  (dn_time),
    .dly_code (rst_dly_code),
    .up_len   (up_len),
    .dn_len   (dn_len),
    .dly_len  (dly_len)
  );

  pss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_i),
    .tick   (tick_us),
    .run    (run),
    .load   (load),
    .len    (load_len),
    .expire (expire)
  );

  pss_fsm #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_i),
    .act_req    (act_req),
    .force_off  (force_off),
    .expire     (expire),
    .up_len     (up_len),
    .dn_len     (dn_len),
    .dly_len    (dly_len),
    .run        (run),
    .load       (load),
    .load_len   (load_len),
    .slot       (slot),
    .evt_up     (evt_up),
    .evt_dn     (evt_dn),
    .sys_rst_n  (sys_rst_n),
    .state_code (seq_state)
  );

  pss_en_bank #(.N_EN(N_EN), .SLOT_W(SLOT_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_i),
    .force_off (force_off),
    .evt_up    (evt_up),
    .evt_dn    (evt_dn),
    .slot      (slot),
    .up_map    (up_slot_map),
    .dn_map    (dn_slot_map),
    .en_q      (en_out)
  );
endmodule

// File: tb/pwr_slot_seq_test.sv
`timescale 1ns/1ps
module pwr_slot_seq_test;
  localparam int N = 12;
  localparam int W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, tick_us, act_req, backup, failsafe, step_sel;
  logic [7:0]   up_time, dn_time;
  logic [N*W-1:0] up_map, dn_map;
  logic [3:0]   dly_code;
  logic [N-1:0] en_out;
  logic         sys_rst_n;
  logic [1:0]   seq_state;

  pwr_slot_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .act_req(act_req),
    .backup(backup), .failsafe(failsafe), .step_sel(step_sel),
    .up_time(up_time), .dn_time(dn_time), .up_slot_map(up_map),
    .dn_slot_map(dn_map), .rst_dly_code(dly_code), .en_out(en_out),
    .sys_rst_n(sys_rst_n), .seq_state(seq_state)
  );

  int cyc = 0;
  int tick_div = 1;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [N-1:0] exp_en;

  typedef struct {
    int           cyc;
    logic [N-1:0] en;
    logic         rst;
    logic [1:0]   code;
    int           rq;
  } item_t;
  item_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  // tick is high on edge j exactly when j is a multiple of tick_div
  initial begin
    tick_us = 1'b0;
    forever begin
      @(negedge clk);
      tick_us = (((cyc + 1) % tick_div) == 0);
    end
  end

  task automatic chk(bit ok, int rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s at cycle %0d: actual=%h expected=%h", rq, what, cyc, act, exp);
    end
  endtask

  // Monitor: pops and compares expected items in their cycle
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        if (sb[0].cyc < cyc) begin
          chk(1'b0, sb[0].rq, "item missed", 32'(cyc), 32'(sb[0].cyc));
        end else begin
          chk(en_out == sb[0].en, sb[0].rq, "en_out", 32'(en_out), 32'(sb[0].en));
          chk(sys_rst_n == sb[0].rst, sb[0].rq, "sys_rst_n", 32'(sys_rst_n), 32'(sb[0].rst));
          chk(seq_state == sb[0].code, sb[0].rq, "seq_state", 32'(seq_state), 32'(sb[0].code));
        end
        void'(sb.pop_front());
      end
    end
  end

  function automatic int step_of();
    return step_sel ? 1000 : 250;
  endfunction

  // R2: slot length = multiplier * step + step/2
  function automatic int slot_len(logic [7:0] t);
    int s = step_of();
    return int'(t) * s + s / 2;
  endfunction

  // R5: two-range delay code
  function automatic int dly_len(logic [3:0] c);
    return c[3] ? (1000 << c[2:0]) : (100 << c[2:0]);
  endfunction

  // edge carrying the n-th tick strictly after edge 'start'
  function automatic int tick_edge(int start, int n);
    int first = (start / tick_div + 1) * tick_div;
    return first + (n - 1) * tick_div;
  endfunction

  function automatic logic [N-1:0] up_mask(int s);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (up_map[i*W +: W] == 4'(s));
    return m;
  endfunction

  function automatic logic [N-1:0] dn_mask(int s);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (dn_map[i*W +: W] == 4'(s));
    return m;
  endfunction

  task automatic add(int c, logic [N-1:0] e, logic r, logic [1:0] code, int rq);
    item_t it;
    int pos;
    it.cyc = c; it.en = e; it.rst = r; it.code = code; it.rq = rq;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].cyc > c) begin
        pos = i;
        break;
      end
    end
    sb.insert(pos, it);
  endtask

  // Driver: value one cycle before the change and value at the change
  task automatic expect_step(int c, logic [N-1:0] e0, logic r0, logic [1:0] c0,
                             logic [N-1:0] e1, logic r1, logic [1:0] c1, int rq);
    if (c - 1 > cyc) add(c - 1, e0, r0, c0, rq);
    add(c, e1, r1, c1, rq);
  endtask

  // Up slots 1..last from load edge k+1
  task automatic plan_up_slots(int k, int last, int rq);
    int L = slot_len(up_time);
    logic [N-1:0] e = exp_en;
    for (int s = 1; s <= last; s++) begin
      logic [N-1:0] ne = e | up_mask(s);
      if (ne != e) expect_step(tick_edge(k + 1, s * L), e, 1'b0, 2'b00, ne, 1'b0, 2'b00, rq);
      e = ne;
    end
    exp_en = e;
  endtask

  task automatic plan_up(int k, int rq, output int c_end);
    int L = slot_len(up_time);
    plan_up_slots(k, 15, rq);
    c_end = tick_edge(k + 1, 15 * L + dly_len(dly_code));
    // R5: release after slot 15 plus the delay
    expect_step(c_end, exp_en, 1'b0, 2'b00, exp_en, 1'b1, 2'b11, 5);
  endtask

  task automatic plan_down(int start, int last, int rq, output int c_end);
    int L = slot_len(dn_time);
    logic [N-1:0] e = exp_en;
    for (int s = 1; s <= last; s++) begin
      logic [N-1:0] ne = e & ~dn_mask(s);
      if (ne != e) expect_step(tick_edge(start, s * L), e, 1'b0, 2'b00, ne, 1'b0, 2'b00, rq);
      e = ne;
    end
    exp_en = e;
    c_end = tick_edge(start, 15 * L);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic run_up(int rq);
    int k, ce;
    @(negedge clk);
    k = cyc;
    plan_up(k, rq, ce);
    act_req = 1'b1;
    wait_until(ce + 2);
  endtask

  task automatic run_down(int rq);
    int k, ce;
    @(negedge clk);
    k = cyc;
    // R6: reset asserted on the edge that sees the low request
    add(k + 1, exp_en, 1'b0, 2'b00, 6);
    plan_down(k + 1, 15, rq, ce);
    act_req = 1'b0;
    wait_until(ce + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  logic [3:0] ups [N];
  logic [3:0] dns [N];

  initial begin
    int k, ce, ca;
    int L;
    ups = '{4'd1, 4'd1, 4'd2, 4'd3, 4'd5, 4'd8, 4'd13, 4'd15, 4'd0, 4'd4, 4'd4, 4'd7};
    dns = '{4'd15, 4'd14, 4'd13, 4'd0, 4'd12, 4'd9, 4'd1, 4'd1, 4'd2, 4'd3, 4'd0, 4'd5};
    for (int i = 0; i < N; i++) begin
      up_map[i*W +: W] = ups[i];
      dn_map[i*W +: W] = dns[i];
    end
    rst_n = 1'b0; act_req = 1'b0; backup = 1'b0; failsafe = 1'b0;
    step_sel = 1'b0; up_time = 8'd0; dn_time = 8'd1; dly_code = 4'd0;
    exp_en = '0;

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(en_out == '0, 1, "en in reset", 32'(en_out), 0);
    chk(sys_rst_n == 1'b0, 1, "rst in reset", 32'(sys_rst_n), 0);
    chk(seq_state == 2'b00, 1, "state in reset", 32'(seq_state), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(en_out == '0 && sys_rst_n == 1'b0 && seq_state == 2'b00, 1, "idle after reset",
        {19'(0), en_out, sys_rst_n}, 0);

    // R3, R5: 250 step, TIME 0, delay code 0; R4 on up slot 0 lane
    run_up(3);
    chk(en_out[8] == 1'b0, 4, "up slot 0 lane stays low", 32'(en_out[8]), 0);
    // R6, R2: down with TIME 1; R4 on down slot 0 lanes
    run_down(6);
    chk(en_out[3] && en_out[10], 4, "down slot 0 lanes stay high", 32'({en_out[10], en_out[3]}), 3);

    // R2: 1000 step, TIME 0 both ways, delay code 3
    step_sel = 1'b1; up_time = 8'd0; dn_time = 8'd0; dly_code = 4'd3;
    run_up(2);
    run_down(2);

    // R7: request dropped on the edge that ends up slot 5
    step_sel = 1'b0; up_time = 8'd2; dn_time = 8'd0; dly_code = 4'd9;
    @(negedge clk);
    k = cyc;
    L = slot_len(up_time);
    plan_up_slots(k, 4, 7);
    ca = tick_edge(k + 1, 5 * L);
    add(ca, exp_en, 1'b0, 2'b00, 7);
    add(ca + 1, exp_en, 1'b0, 2'b00, 7);
    act_req = 1'b1;
    wait_until(ca - 1);
    act_req = 1'b0;
    plan_down(ca, 15, 7, ce);
    wait_until(ce + 2);

    // R7: request raised on the edge that ends down slot 2
    run_up(3);
    @(negedge clk);
    k = cyc;
    add(k + 1, exp_en, 1'b0, 2'b00, 6);
    plan_down(k + 1, 1, 7, ce);
    ca = tick_edge(k + 1, 2 * slot_len(dn_time));
    add(ca, exp_en, 1'b0, 2'b00, 7);
    act_req = 1'b0;
    wait_until(ca - 1);
    act_req = 1'b1;
    plan_up(ca - 1, 7, ce);
    wait_until(ce + 2);
    run_down(6);

    // R8: backup on the edge that ends up slot 3
    up_time = 8'd0;
    @(negedge clk);
    k = cyc;
    plan_up_slots(k, 2, 8);
    ca = tick_edge(k + 1, 3 * slot_len(up_time));
    add(ca - 1, exp_en, 1'b0, 2'b00, 8);
    add(ca, '0, 1'b0, 2'b00, 8);
    exp_en = '0;
    act_req = 1'b1;
    wait_until(ca - 1);
    backup = 1'b1;
    wait_until(ca + 400);
    chk(en_out == '0 && sys_rst_n == 1'b0 && seq_state == 2'b00, 8, "held in shutdown",
        {19'(0), en_out, sys_rst_n}, 0);
    // R8: release with request high restarts from slot 1
    k = cyc;
    backup = 1'b0;
    plan_up(k, 8, ce);
    wait_until(ce + 2);

    // R8: failsafe while active
    @(negedge clk);
    k = cyc;
    add(k + 1, '0, 1'b0, 2'b00, 8);
    exp_en = '0;
    failsafe = 1'b1;
    act_req = 1'b0;
    repeat (50) @(negedge clk);
    failsafe = 1'b0;
    repeat (100) @(negedge clk);
    chk(en_out == '0 && sys_rst_n == 1'b0 && seq_state == 2'b00, 8, "stays off after failsafe",
        {19'(0), en_out, sys_rst_n}, 0);

    // R9: one tick every third cycle
    step_sel = 1'b0; up_time = 8'd0; dn_time = 8'd0; dly_code = 4'd0;
    tick_div = 3;
    repeat (4) @(negedge clk);
    run_up(9);
    run_down(9);
    tick_div = 1;
    repeat (4) @(negedge clk);

    chk(sb.size() == 0, 9, "scoreboard drained", 32'(sb.size()), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule